// File: doc/BRIEF.md
# Single-Wire Bus Transaction Sequencer

This block runs one complete command transaction on a single-wire open-drain bus. It sits on top of a separate bit-slot engine that produces the actual waveforms. The sequencer only decides which slot comes next: a reset with presence detect, a write-0, a write-1 or a read. It also chooses regular or overdrive timing for that slot, and it collects the bits that come back.

A transaction is loaded in one `start` cycle. That cycle supplies four lengths, two write buffers, an overdrive flag and a bit-granular read flag.

- **Reset.** The sequencer first resets the bus. A reset that sees no device is retried a bounded number of times. A wiring fault stops the transaction at once.
- **Device-select layer.** It streams the selection bytes out and reads the selection response in, always at regular timing.
- **Transport layer.** It then writes the transport bytes and reads the transport data. This layer runs at overdrive timing when the flag asks for it. The read count is in bytes, or in bits when bit mode is selected.
- **Completion.** When the transaction ends, a one-cycle `done` pulse appears together with an error code. The two read buffers hold their results until the next transaction starts.

Top module: `owseq_top`

## Requirements
- R1: `start` is accepted only while `busy` is low. `busy` rises in the cycle after acceptance. A `start` pulse while `busy` is high changes neither the running transaction nor its results.
- R2: Slot codes on `slot_op` are 0 reset, 1 write-0, 2 write-1 and 3 read. Every byte is sent least significant bit first, one slot per bit.
- R3: Presence codes on `slot_pres` are 0 device present, 1 no device, and 2 or 3 wiring fault. A "no device" result causes another reset. After the fifth consecutive "no device" result, the transaction ends with error code 1 and issues no further slot.
- R4: A wiring fault ends the transaction immediately with error code 2. There is no retry and no further slot.
- R5: Reset slots and every device-select slot (write or read) are issued with `slot_fast` low.
- R6: Every transport-layer slot carries `slot_fast` equal to the overdrive flag captured at start.
- R7: The k-th bit read in a read phase is stored in its buffer at byte k/8, bit k%8. Both buffers are flat vectors, so that is vector bit k.
- R8: Both read buffers are cleared to zero when a transaction is accepted. In bit mode, `xpt_rd_len` is a count of bits rather than bytes.
- R9: Slots follow the order: reset, device-select writes, device-select reads, transport writes, transport reads. A phase whose length is zero issues no slot.
- R10: When `xpt_wr_len` is zero, the whole transport layer is skipped, including its reads.
- R11: `done` is a single-cycle pulse, raised with `busy` low. `err_code` is 0 on success and stays valid until the next start. After reset, `busy`, `done`, `err_code`, `slot_req` and both buffers are zero.
- R12: `slot_req` stays high, with `slot_op` and `slot_fast` stable, until `slot_done`. It drops in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transaction (idle only) |
| rom_wr_len | input | 4 | Device-select bytes to write |
| rom_wr_buf | input | 64 | Device-select write bytes, byte 0 in bits 7:0 |
| rom_rd_len | input | 4 | Device-select bytes to read |
| xpt_wr_len | input | 4 | Transport bytes to write |
| xpt_wr_buf | input | 64 | Transport write bytes, byte 0 in bits 7:0 |
| xpt_rd_len | input | 7 | Transport read length, in bytes or in bits (bit mode) |
| ovd_en | input | 1 | Run the transport layer at overdrive timing |
| bit_rd_mode | input | 1 | Transport read length counts bits |
| slot_req | output | 1 | Slot request to the bit-slot engine |
| slot_op | output | 2 | Slot kind (see R2) |
| slot_fast | output | 1 | Overdrive timing for this slot |
| slot_done | input | 1 | Slot finished; `slot_bit` and `slot_pres` are valid |
| slot_bit | input | 1 | Bit sampled by a read slot |
| slot_pres | input | 2 | Presence result of a reset slot (see R3) |
| rom_rd_buf | output | 64 | Device-select read data |
| xpt_rd_buf | output | 64 | Transport read data |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | Transaction finished (one cycle) |
| err_code | output | 2 | 0 ok, 1 no device, 2 wiring fault |

## Verification
Some properties are checked by the assertions on every cycle:

- the request handshake: a held request with stable slot kind and speed, and the drop after completion;
- regular timing on resets and on device-select slots;
- the single-cycle `done`, raised with `busy` low;
- the bound on the reset try counter;
- the freezing of the captured lengths while busy.

Other properties can only be shown by the scenarios. These include the exact slot sequence, including zero-length phases and the skipped transport layer. They also include the retry count before a not-found error, the immediate wiring-fault abort, the placement of read bits in byte and bit mode, and the clearing of old buffer contents.

// File: rtl/owseq_pkg.sv
package owseq_pkg;

  typedef enum logic [1:0] {
    OP_RESET = 2'd0,
    OP_WR0   = 2'd1,
    OP_WR1   = 2'd2,
    OP_READ  = 2'd3
  } slot_op_e;

  localparam logic [1:0] PRES_OK   = 2'd0;
  localparam logic [1:0] PRES_NONE = 2'd1;

  localparam logic [1:0] ERR_NONE   = 2'd0;
  localparam logic [1:0] ERR_ABSENT = 2'd1;
  localparam logic [1:0] ERR_WIRING = 2'd2;

  typedef enum logic [2:0] {
    PH_RST,
    PH_ROMW,
    PH_ROMR,
    PH_XW,
    PH_XR,
    PH_END
  } phase_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_ADV
  } state_e;

endpackage

// File: rtl/owseq_rdbuf.sv
module owseq_rdbuf #(
  parameter int BYTES = 8,
  parameter int IW    = 7
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic                 we,
  input  logic [IW-1:0]        idx,
  input  logic                 din,
  output logic [BYTES*8-1:0]   data
);
  localparam int NB = BYTES * 8;

  for (genvar b = 0; b < NB; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst || clr)
        data[b] <= 1'b0;
      else if (we && (idx == IW'(b)))
        data[b] <= din;
    end
  end

  // R7: a read bit never lands outside the buffer
  p_idx_in_range_r7: assert property (@(posedge clk) disable iff (rst)
    we |-> (int'(idx) < NB));

endmodule

// File: rtl/owseq_ctrl.sv
module owseq_ctrl
  import owseq_pkg::*;
#(
  parameter int ROM_WR_BYTES = 8,
  parameter int ROM_RD_BYTES = 8,
  parameter int XPT_WR_BYTES = 8,
  parameter int XPT_RD_BYTES = 8,
  parameter int RESET_TRIES  = 5,
  localparam int RWL_W = $clog2(ROM_WR_BYTES + 1),
  localparam int RRL_W = $clog2(ROM_RD_BYTES + 1),
  localparam int XWL_W = $clog2(XPT_WR_BYTES + 1),
  localparam int XRL_W = $clog2(XPT_RD_BYTES * 8 + 1),
  localparam int MAXB  = (ROM_WR_BYTES > ROM_RD_BYTES ?
                          (ROM_WR_BYTES > XPT_WR_BYTES ?
                           (ROM_WR_BYTES > XPT_RD_BYTES ? ROM_WR_BYTES : XPT_RD_BYTES) :
                           (XPT_WR_BYTES > XPT_RD_BYTES ? XPT_WR_BYTES : XPT_RD_BYTES)) :
                          (ROM_RD_BYTES > XPT_WR_BYTES ?
                           (ROM_RD_BYTES > XPT_RD_BYTES ? ROM_RD_BYTES : XPT_RD_BYTES) :
                           (XPT_WR_BYTES > XPT_RD_BYTES ? XPT_WR_BYTES : XPT_RD_BYTES))),
  localparam int CNT_W = $clog2(MAXB * 8 + 1)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic [RWL_W-1:0]          rom_wr_len,
  input  logic [ROM_WR_BYTES*8-1:0] rom_wr_buf,
  input  logic [RRL_W-1:0]          rom_rd_len,
  input  logic [XWL_W-1:0]          xpt_wr_len,
  input  logic [XPT_WR_BYTES*8-1:0] xpt_wr_buf,
  input  logic [XRL_W-1:0]          xpt_rd_len,
  input  logic                      ovd_en,
  input  logic                      bit_rd_mode,
  output logic                      slot_req,
  output logic [1:0]                slot_op,
  output logic                      slot_fast,
  input  logic                      slot_done,
  input  logic                      slot_bit,
  input  logic [1:0]                slot_pres,
  output logic                      rd_clr,
  output logic                      rom_we,
  output logic                      xpt_we,
  output logic [CNT_W-1:0]          rd_idx,
  output logic                      rd_bit,
  output logic                      busy,
  output logic                      done,
  output logic [1:0]                err_code
);
  localparam int TRY_W = $clog2(RESET_TRIES + 1);
  localparam int RWB   = ROM_WR_BYTES * 8;
  localparam int XWB   = XPT_WR_BYTES * 8;

  state_e                  state_q;
  phase_e                  phase_q, nxt_phase;
  logic [CNT_W-1:0]        cnt_q, tot_cur;
  logic [TRY_W-1:0]        tries_q;
  logic [RWL_W-1:0]        rwl_q;
  logic [RRL_W-1:0]        rrl_q;
  logic [XWL_W-1:0]        xwl_q;
  logic [XRL_W-1:0]        xrl_q;
  logic                    ovd_q, bitm_q;
  logic [RWB-1:0]          rwbuf_q;
  logic [XWB-1:0]          xwbuf_q;
  logic                    wbit;
  logic                    rw_nz, rr_nz, xw_nz, xr_nz;

  assign busy  = (state_q != ST_IDLE);
  assign rw_nz = (rwl_q != '0);
  assign rr_nz = (rrl_q != '0);
  assign xw_nz = (xwl_q != '0);
  assign xr_nz = (xrl_q != '0);

  // phase successor, skipping empty phases; transport reads only follow writes
  always_comb begin
    case (phase_q)
      PH_RST:  nxt_phase = rw_nz ? PH_ROMW : rr_nz ? PH_ROMR : xw_nz ? PH_XW : PH_END;
      PH_ROMW: nxt_phase = rr_nz ? PH_ROMR : xw_nz ? PH_XW : PH_END;
      PH_ROMR: nxt_phase = xw_nz ? PH_XW : PH_END;
      PH_XW:   nxt_phase = xr_nz ? PH_XR : PH_END;
      default: nxt_phase = PH_END;
    endcase
  end

  // slot count of the current phase
  always_comb begin
    case (phase_q)
      PH_ROMW: tot_cur = CNT_W'({rwl_q, 3'b000});
      PH_ROMR: tot_cur = CNT_W'({rrl_q, 3'b000});
      PH_XW:   tot_cur = CNT_W'({xwl_q, 3'b000});
      PH_XR:   tot_cur = bitm_q ? CNT_W'(xrl_q) : CNT_W'({xrl_q, 3'b000});
      default: tot_cur = '0;
    endcase
  end

  // write bit selected by the slot counter, LSB of byte 0 first
  always_comb begin
    wbit = 1'b0;
    if (phase_q == PH_ROMW) begin
      for (int b = 0; b < RWB; b++)
        if (cnt_q == CNT_W'(b)) wbit = rwbuf_q[b];
    end else begin
      for (int b = 0; b < XWB; b++)
        if (cnt_q == CNT_W'(b)) wbit = xwbuf_q[b];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      phase_q   <= PH_RST;
      cnt_q     <= '0;
      tries_q   <= '0;
      rwl_q     <= '0;
      rrl_q     <= '0;
      xwl_q     <= '0;
      xrl_q     <= '0;
      ovd_q     <= 1'b0;
      bitm_q    <= 1'b0;
      rwbuf_q   <= '0;
      xwbuf_q   <= '0;
      slot_req  <= 1'b0;
      slot_op   <= OP_RESET;
      slot_fast <= 1'b0;
      rd_clr    <= 1'b0;
      rom_we    <= 1'b0;
      xpt_we    <= 1'b0;
      rd_idx    <= '0;
      rd_bit    <= 1'b0;
      done      <= 1'b0;
      err_code  <= ERR_NONE;
    end else begin
      done   <= 1'b0;
      rd_clr <= 1'b0;
      rom_we <= 1'b0;
      xpt_we <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            rwl_q    <= rom_wr_len;
            rrl_q    <= rom_rd_len;
            xwl_q    <= xpt_wr_len;
            xrl_q    <= xpt_rd_len;
            ovd_q    <= ovd_en;
            bitm_q   <= bit_rd_mode;
            rwbuf_q  <= rom_wr_buf;
            xwbuf_q  <= xpt_wr_buf;
            phase_q  <= PH_RST;
            cnt_q    <= '0;
            tries_q  <= TRY_W'(1);
            rd_clr   <= 1'b1;
            err_code <= ERR_NONE;
            state_q  <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          slot_req  <= 1'b1;
          slot_fast <= ovd_q && (phase_q == PH_XW || phase_q == PH_XR);
          if (phase_q == PH_RST)
            slot_op <= OP_RESET;
          else if (phase_q == PH_ROMR || phase_q == PH_XR)
            slot_op <= OP_READ;
          else
            slot_op <= wbit ? OP_WR1 : OP_WR0;
          state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (slot_done) begin
            slot_req <= 1'b0;
            if (phase_q == PH_RST) begin
              if (slot_pres == PRES_OK) begin
                state_q <= ST_ADV;
              end else if (slot_pres == PRES_NONE) begin
                if (tries_q == TRY_W'(RESET_TRIES)) begin
                  done     <= 1'b1;
                  err_code <= ERR_ABSENT;
                  state_q  <= ST_IDLE;
                end else begin
                  tries_q <= tries_q + TRY_W'(1);
                  state_q <= ST_ISSUE;
                end
              end else begin
                done     <= 1'b1;
                err_code <= ERR_WIRING;
                state_q  <= ST_IDLE;
              end
            end else begin
              rom_we <= (phase_q == PH_ROMR);
              xpt_we <= (phase_q == PH_XR);
              rd_idx <= cnt_q;
              rd_bit <= slot_bit;
              if ((cnt_q + CNT_W'(1)) == tot_cur) begin
                state_q <= ST_ADV;
              end else begin
                cnt_q   <= cnt_q + CNT_W'(1);
                state_q <= ST_ISSUE;
              end
            end
          end
        end
        default: begin  // ST_ADV
          phase_q <= nxt_phase;
          cnt_q   <= '0;
          if (nxt_phase == PH_END) begin
            done     <= 1'b1;
            err_code <= ERR_NONE;
            state_q  <= ST_IDLE;
          end else begin
            state_q <= ST_ISSUE;
          end
        end
      endcase
    end
  end

  // R12: request held with stable kind and speed until the engine answers
  p_req_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (slot_req && !slot_done) |=> (slot_req && $stable(slot_op) && $stable(slot_fast)));
  // R12: request withdrawn right after completion
  p_req_drop_r12: assert property (@(posedge clk) disable iff (rst)
    (slot_req && slot_done) |=> !slot_req);
  // R5: resets always at regular timing
  p_reset_regular_r5: assert property (@(posedge clk) disable iff (rst)
    (slot_req && slot_op == OP_RESET) |-> !slot_fast);
  // R5: device-select slots at regular timing
  p_select_regular_r5: assert property (@(posedge clk) disable iff (rst)
    (slot_req && (phase_q == PH_ROMW || phase_q == PH_ROMR)) |-> !slot_fast);
  // R3: reset attempts bounded
  p_tries_bound_r3: assert property (@(posedge clk) disable iff (rst)
    busy |-> (tries_q <= TRY_W'(RESET_TRIES)));
  // R11: done is one cycle and coincides with idle
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_idle_r11: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R1: start while busy leaves the captured transaction untouched
  p_busy_ignore_r1: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> ($stable(rwl_q) && $stable(xwl_q) && $stable(xrl_q) && $stable(ovd_q)));

endmodule

// File: rtl/owseq_top.sv
module owseq_top #(
  parameter int ROM_WR_BYTES = 8,
  parameter int ROM_RD_BYTES = 8,
  parameter int XPT_WR_BYTES = 8,
  parameter int XPT_RD_BYTES = 8,
  parameter int RESET_TRIES  = 5
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  start,
  input  logic [$clog2(ROM_WR_BYTES+1)-1:0]     rom_wr_len,
  input  logic [ROM_WR_BYTES*8-1:0]             rom_wr_buf,
  input  logic [$clog2(ROM_RD_BYTES+1)-1:0]     rom_rd_len,
  input  logic [$clog2(XPT_WR_BYTES+1)-1:0]     xpt_wr_len,
  input  logic [XPT_WR_BYTES*8-1:0]             xpt_wr_buf,
  input  logic [$clog2(XPT_RD_BYTES*8+1)-1:0]   xpt_rd_len,
  input  logic                                  ovd_en,
  input  logic                                  bit_rd_mode,
  output logic                                  slot_req,
  output logic [1:0]                            slot_op,
  output logic                                  slot_fast,
  input  logic                                  slot_done,
  input  logic                                  slot_bit,
  input  logic [1:0]                            slot_pres,
  output logic [ROM_RD_BYTES*8-1:0]             rom_rd_buf,
  output logic [XPT_RD_BYTES*8-1:0]             xpt_rd_buf,
  output logic                                  busy,
  output logic                                  done,
  output logic [1:0]                            err_code
);
  localparam int MAXB = (ROM_WR_BYTES > ROM_RD_BYTES ?
                         (ROM_WR_BYTES > XPT_WR_BYTES ?
                          (ROM_WR_BYTES > XPT_RD_BYTES ? ROM_WR_BYTES : XPT_RD_BYTES) :
                          (XPT_WR_BYTES > XPT_RD_BYTES ? XPT_WR_BYTES : XPT_RD_BYTES)) :
                         (ROM_RD_BYTES > XPT_WR_BYTES ?
                          (ROM_RD_BYTES > XPT_RD_BYTES ? ROM_RD_BYTES : XPT_RD_BYTES) :
                          (XPT_WR_BYTES > XPT_RD_BYTES ? XPT_WR_BYTES : XPT_RD_BYTES)));
  localparam int CNT_W = $clog2(MAXB * 8 + 1);

  logic             rd_clr, rom_we, xpt_we, rd_bit;
  logic [CNT_W-1:0] rd_idx;

  owseq_ctrl #(
    .ROM_WR_BYTES(ROM_WR_BYTES), .ROM_RD_BYTES(ROM_RD_BYTES),
    .XPT_WR_BYTES(XPT_WR_BYTES), .XPT_RD_BYTES(XPT_RD_BYTES),
    .RESET_TRIES (RESET_TRIES)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .rom_wr_len (rom_wr_len),
    .rom_wr_buf (rom_wr_buf),
    .rom_rd_len (rom_rd_len),
    .xpt_wr_len (xpt_wr_len),
    .xpt_wr_buf (xpt_wr_buf),
    .xpt_rd_len (xpt_rd_len),
    .ovd_en     (ovd_en),
    .bit_rd_mode(bit_rd_mode),
    .slot_req   (slot_req),
    .slot_op    (slot_op),
    .slot_fast  (slot_fast),
    .slot_done  (slot_done),
    .slot_bit   (slot_bit),
    .slot_pres  (slot_pres),
    .rd_clr     (rd_clr),
    .rom_we     (rom_we),
    .xpt_we     (xpt_we),
    .rd_idx     (rd_idx),
    .rd_bit     (rd_bit),
    .busy       (busy),
    .done       (done),
    .err_code   (err_code)
  );

  owseq_rdbuf #(.BYTES(ROM_RD_BYTES), .IW(CNT_W)) u_rom_buf (
    .clk (clk),
    .rst (rst),
    .clr (rd_clr),
    .we  (rom_we),
    .idx (rd_idx),
    .din (rd_bit),
    .data(rom_rd_buf)
  );

  owseq_rdbuf #(.BYTES(XPT_RD_BYTES), .IW(CNT_W)) u_xpt_buf (
    .clk (clk),
    .rst (rst),
    .clr (rd_clr),
    .we  (xpt_we),
    .idx (rd_idx),
    .din (rd_bit),
    .data(xpt_rd_buf)
  );

endmodule

// File: tb/owseq_top_tb_top.sv
module owseq_top_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic [3:0]  rom_wr_len, rom_rd_len, xpt_wr_len;
  logic [63:0] rom_wr_buf, xpt_wr_buf;
  logic [6:0]  xpt_rd_len;
  logic        ovd_en, bit_rd_mode;
  logic        slot_req, slot_fast, slot_done, slot_bit;
  logic [1:0]  slot_op, slot_pres, err_code;
  logic [63:0] rom_rd_buf, xpt_rd_buf;
  logic        busy, done;

  always #4 clk = ~clk;  // 125 MHz

  owseq_top dut_i (
    .clk(clk), .rst(rst), .start(start),
    .rom_wr_len(rom_wr_len), .rom_wr_buf(rom_wr_buf), .rom_rd_len(rom_rd_len),
    .xpt_wr_len(xpt_wr_len), .xpt_wr_buf(xpt_wr_buf), .xpt_rd_len(xpt_rd_len),
    .ovd_en(ovd_en), .bit_rd_mode(bit_rd_mode),
    .slot_req(slot_req), .slot_op(slot_op), .slot_fast(slot_fast),
    .slot_done(slot_done), .slot_bit(slot_bit), .slot_pres(slot_pres),
    .rom_rd_buf(rom_rd_buf), .xpt_rd_buf(xpt_rd_buf),
    .busy(busy), .done(done), .err_code(err_code)
  );

  int          n_vec = 0;
  int          n_bad = 0;
  bit          finished = 1'b0;
  logic [2:0]  exp_q[$];          // {fast, op} per expected slot
  logic [1:0]  pres_script[$];    // presence answers for successive resets
  logic [127:0] stream = 128'h9E37_79B9_7F4A_7C15_F39C_C060_5CED_C834;
  int          rd_ptr = 0;

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor and slot engine model: pops the scoreboard on each request
  initial begin
    slot_done = 1'b0;
    slot_bit  = 1'b0;
    slot_pres = 2'd0;
    forever begin
      @(negedge clk);
      if (slot_req === 1'b1) begin
        logic [2:0] got;
        logic [2:0] e;
        got = {slot_fast, slot_op};
        if (exp_q.size() == 0) begin
          chk(1'b0, "R9 unexpected slot", got, 0);
        end else begin
          e = exp_q.pop_front();
          if (e[2])
            chk(got == e, "R6 transport slot", got, e);
          else if (e[1:0] == 2'd0)
            chk(got == e, "R5 reset slot", got, e);
          else
            chk(got == e, "R2 slot kind/order", got, e);
        end
        repeat (2) @(negedge clk);
        slot_bit  = 1'b0;
        slot_pres = 2'd0;
        if (slot_op == 2'd3) begin
          slot_bit = stream[rd_ptr];
          rd_ptr++;
        end
        if (slot_op == 2'd0 && pres_script.size() > 0)
          slot_pres = pres_script.pop_front();
        slot_done = 1'b1;
        @(negedge clk);
        slot_done = 1'b0;
        chk(slot_req == 1'b0, "R12 request drop", slot_req, 0);
      end
    end
  end

  task automatic run_txn(input int rwl, input logic [63:0] rwb, input int rrl,
                         input int xwl, input logic [63:0] xwb, input int xrl,
                         input bit ovd, input bit bitm, input int n_resets,
                         input int exp_err, input bit poke, input string tag);
    logic [63:0] erom, expt;
    int nxr;
    bit seen;
    exp_q.delete();
    rd_ptr = 0;
    erom = '0;
    expt = '0;
    nxr = bitm ? xrl : xrl * 8;
    for (int i = 0; i < n_resets; i++) exp_q.push_back(3'b000);
    if (exp_err == 0) begin
      for (int i = 0; i < rwl * 8; i++) exp_q.push_back({1'b0, rwb[i] ? 2'd2 : 2'd1});
      for (int i = 0; i < rrl * 8; i++) begin
        exp_q.push_back(3'b011);
        erom[i] = stream[i];
      end
      if (xwl != 0) begin
        for (int i = 0; i < xwl * 8; i++) exp_q.push_back({ovd, xwb[i] ? 2'd2 : 2'd1});
        for (int i = 0; i < nxr; i++) begin
          exp_q.push_back({ovd, 2'd3});
          expt[i] = stream[rrl * 8 + i];
        end
      end
    end
    @(negedge clk);
    rom_wr_len = 4'(rwl); rom_wr_buf = rwb; rom_rd_len = 4'(rrl);
    xpt_wr_len = 4'(xwl); xpt_wr_buf = xwb; xpt_rd_len = 7'(xrl);
    ovd_en = ovd; bit_rd_mode = bitm;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R1 accept when idle", busy, 1);
    if (poke) begin
      repeat (5) @(negedge clk);
      rom_wr_len = 4'd0; xpt_wr_len = 4'd0; ovd_en = ~ovd;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R1 start ignored while busy", busy, 1);
    end
    seen = 1'b0;
    for (int c = 0; c < 20000 && !seen; c++) begin
      if (done === 1'b1) seen = 1'b1;
      else @(negedge clk);
    end
    chk(seen, {tag, " done reached"}, seen, 1);
    chk(err_code == 2'(exp_err), {tag, " error code"}, err_code, exp_err);
    chk(busy == 1'b0, "R11 idle at done", busy, 0);
    chk(exp_q.size() == 0, "R9 all expected slots issued", exp_q.size(), 0);
    chk(rom_rd_buf == erom, "R7 select read buffer", rom_rd_buf, erom);
    chk(xpt_rd_buf == expt, "R8 transport read buffer", xpt_rd_buf, expt);
    @(negedge clk);
    chk(done == 1'b0, "R11 done single cycle", done, 0);
    pres_script.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog R11 actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; start = 1'b0;
    rom_wr_len = '0; rom_rd_len = '0; xpt_wr_len = '0; xpt_rd_len = '0;
    rom_wr_buf = '0; xpt_wr_buf = '0; ovd_en = 1'b0; bit_rd_mode = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk({busy, done, slot_req, err_code} == 5'b0, "R11 reset state",
        {busy, done, slot_req, err_code}, 0);
    chk(rom_rd_buf == '0 && xpt_rd_buf == '0, "R11 reset buffers",
        rom_rd_buf ^ xpt_rd_buf, 0);

    // regular speed, byte reads (R2, R7, R9)
    run_txn(2, 64'hA5CC, 1, 2, 64'h3C0F, 2, 1'b0, 1'b0, 1, 0, 1'b0, "R2");
    // overdrive transport, bit-mode read of 11 bits, start poked while busy (R1, R6, R8)
    run_txn(1, 64'h55, 2, 1, 64'hB4, 11, 1'b1, 1'b1, 1, 0, 1'b1, "R6");
    // two missing presences then a device (R3)
    pres_script.push_back(2'd1); pres_script.push_back(2'd1); pres_script.push_back(2'd0);
    run_txn(1, 64'hF0, 1, 1, 64'h0F, 1, 1'b0, 1'b0, 3, 0, 1'b0, "R3 retry");
    // no device at all: five resets then not-found (R3)
    for (int i = 0; i < 6; i++) pres_script.push_back(2'd1);
    run_txn(1, 64'hF0, 1, 1, 64'h0F, 1, 1'b0, 1'b0, 5, 1, 1'b0, "R3 not found");
    // wiring fault: one reset, immediate abort (R4)
    pres_script.push_back(2'd2);
    run_txn(1, 64'hF0, 1, 1, 64'h0F, 1, 1'b0, 1'b0, 1, 2, 1'b0, "R4 wiring");
    pres_script.push_back(2'd3);
    run_txn(0, 64'h0, 0, 0, 64'h0, 0, 1'b0, 1'b0, 1, 2, 1'b0, "R4 wiring code 3");
    // transport writes empty: reads skipped as well (R10)
    run_txn(1, 64'h33, 1, 0, 64'h0, 3, 1'b1, 1'b0, 1, 0, 1'b0, "R10");
    // every length zero: reset only (R9)
    run_txn(0, 64'h0, 0, 0, 64'h0, 0, 1'b1, 1'b0, 1, 0, 1'b0, "R9 empty");
    // single-bit read in bit mode, only transport layer present (R8)
    run_txn(0, 64'h0, 0, 1, 64'h81, 1, 1'b0, 1'b1, 1, 0, 1'b0, "R8 one bit");
    // full buffers (R7)
    run_txn(8, 64'h0123_4567_89AB_CDEF, 8, 8, 64'hFEDC_BA98_7654_3210, 8,
            1'b1, 1'b0, 1, 0, 1'b0, "R7 full");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule